// File: doc/BRIEF.md
# SPI Master with Programmable Baud Divider

This block is a synchronous serial master. It sends one character on a data-out line and, at the same time, captures one character from a data-in line. The serial clock comes from a programmable divider of the module clock. Software picks the character length (8 or 16 bits), which end of the word goes first, the clock phase, the clock polarity and an 8-bit divisor. It then writes one transmit character through a valid/ready pair.

When the transfer finishes, the received character sits right-justified in a 16-bit holding output and a receive-ready flag goes high. An idle flag reports that no transfer is running and that the serial clock is at its rest level. Software drives chip select itself, and should release it only once both flags are high. The format and the divisor are captured when a transfer starts, so later changes to them wait for the next character.

Top module: `spim_master`

## Requirements
- R1: Let D be `cfg_div`, with 0 treated as 1. Each serial-clock half period lasts D+1 module-clock cycles, so the period is 2×(D+1). An n-bit transfer keeps `idle` low for exactly 2·n·(D+1) cycles, starting from the cycle after acceptance.
- R2: `cfg_wide`=0 selects 8-bit characters and `cfg_wide`=1 selects 16-bit characters. For 8-bit characters only `tx_data[7:0]` is sent.
- R3: `cfg_lsb_first`=1 sends and receives bit 0 first. `cfg_lsb_first`=0 sends and receives the top bit of the character first.
- R4: With `cfg_cpha`=0, the first bit is on `mosi` from the cycle after acceptance, `miso` is sampled on each leading clock edge, and `mosi` changes on trailing edges. With `cfg_cpha`=1, `mosi` changes on leading edges after the first, and `miso` is sampled on trailing edges.
- R5: While `idle` is high, `sclk` equals `cfg_cpol` and `mosi` is 0. `idle` is low during a transfer.
- R6: `tx_ready` equals `idle`. A `tx_valid` pulse seen while busy is ignored: it changes neither the data being shifted nor the transfer length.
- R7: `rx_data` holds the last received character, right-justified. In 8-bit mode bits 15:8 read 0.
- R8: `rx_ready` rises in the cycle after the last bit is sampled and stays high until an `rx_read` pulse clears it. If a clear and a new last sample land in the same cycle, the set wins.
- R9: Width, bit order, phase, polarity and divisor are latched when a character is accepted. Changing them mid-transfer has no effect on that transfer.
- R10: After reset, `idle`=1, `tx_ready`=1, `rx_ready`=0, `rx_data`=0 and `mosi`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 8 | Baud divisor D (0 acts as 1) |
| cfg_wide | input | 1 | 1 = 16-bit character, 0 = 8-bit |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_cpol | input | 1 | Clock rest level |
| tx_data | input | 16 | Character to send |
| tx_valid | input | 1 | Request to start a transfer |
| tx_ready | output | 1 | Block can accept a character |
| rx_data | output | 16 | Last received character, right-justified |
| rx_ready | output | 1 | Unread received character present |
| rx_read | input | 1 | Pulse that clears rx_ready |
| idle | output | 1 | No transfer running and clock at rest |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bound checker watches, on every cycle, the properties that hold in every mode:
- the rest level of `sclk` and `mosi` while idle;
- that an accepted write takes the block out of idle;
- that `tx_ready` is low while busy;
- that `rx_ready` stays set until it is read and clears on a read while idle;
- that the serial clock never toggles on two cycles in a row.

Only the bench scenarios can show the rest. These are the exact half-period length for each divisor, including 0 and 255, and the bit ordering and sampling edge in all four phase/polarity modes. They also cover right-justification of 8-bit characters, that format changes mid-transfer are ignored, and the set-over-clear priority of `rx_ready`. The bench's cycle-level model checks these against the outputs on every clock.

// File: rtl/spim_pkg.sv
package spim_pkg;
  // Transfer format captured when a character is accepted.
  typedef struct packed {
    logic wide;       // 1: long character, 0: short character
    logic lsb_first;  // bit 0 travels first
    logic cpha;       // 0: sample on leading edge, 1: on trailing edge
    logic cpol;       // rest level of the serial clock
  } spim_fmt_t;
endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_eff;

  // A divisor of zero is reserved and acts as one.
  assign div_eff = (div_in == '0) ? DIV_W'(1) : div_in;
  assign tick    = run && (cnt_q == div_q);

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q;
    if (load) begin
      div_d = div_eff;
      cnt_d = '0;
    end else if (run) begin
      cnt_d = tick ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(1);
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  spim_fmt_t         fmt_in,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              rx_read,
  input  logic              tick,
  input  logic              miso,
  output logic              start,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_ready
);
  localparam int EDGE_W = $clog2(2 * WORD_W + 1);
  localparam int IDX_W  = EDGE_W - 1;

  function automatic logic [WORD_W-1:0] flip(input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = v[WORD_W-1-i];
    return r;
  endfunction

  logic              busy_q, busy_d;
  logic [EDGE_W-1:0] eidx_q, eidx_d;
  spim_fmt_t         fmt_q, fmt_d;
  logic [WORD_W-1:0] tx_q, tx_d;
  logic [WORD_W-1:0] rxs_q, rxs_d;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              rdy_q, rdy_d;

  logic              lead, last_edge, sample_ev, shift_ev, last_sample;
  logic [IDX_W-1:0]  last_idx;
  logic [WORD_W-1:0] rx_in, rx_word;

  assign start     = tx_valid && !busy_q;
  assign lead      = !eidx_q[0];
  assign last_edge = fmt_q.wide ? (eidx_q == EDGE_W'(2 * WORD_W - 1))
                                : (eidx_q == EDGE_W'(2 * NARROW_W - 1));
  assign last_idx  = fmt_q.wide ? IDX_W'(WORD_W - 1) : IDX_W'(NARROW_W - 1);
  assign sample_ev = tick && (fmt_q.cpha ? !lead : lead);
  assign shift_ev  = tick && (fmt_q.cpha ? (lead && eidx_q != '0)
                                         : (!lead && !last_edge));
  assign last_sample = sample_ev && (eidx_q[EDGE_W-1:1] == last_idx);
  assign rx_in     = {rxs_q[WORD_W-2:0], miso};

  // Receive shifter holds first bit highest; normalise to right-justified.
  always_comb begin
    if (fmt_q.lsb_first) begin
      rx_word = fmt_q.wide ? flip(rx_in) : (flip(rx_in) >> (WORD_W - NARROW_W));
    end else begin
      rx_word = fmt_q.wide ? rx_in : (rx_in & WORD_W'((1 << NARROW_W) - 1));
    end
  end

  always_comb begin
    busy_d = busy_q;
    eidx_d = eidx_q;
    fmt_d  = fmt_q;
    tx_d   = tx_q;
    rxs_d  = rxs_q;
    hold_d = hold_q;
    rdy_d  = rdy_q;
    if (start) begin
      busy_d = 1'b1;
      eidx_d = '0;
      fmt_d  = fmt_in;
      rxs_d  = '0;
      if (fmt_in.lsb_first) tx_d = flip(tx_data);
      else if (fmt_in.wide) tx_d = tx_data;
      else                  tx_d = tx_data << (WORD_W - NARROW_W);
    end else if (tick) begin
      eidx_d = eidx_q + 1'b1;
      if (sample_ev) rxs_d = rx_in;
      if (shift_ev)  tx_d  = {tx_q[WORD_W-2:0], 1'b0};
      if (last_edge) busy_d = 1'b0;
    end
    if (rx_read) rdy_d = 1'b0;
    if (last_sample) begin
      rdy_d  = 1'b1;
      hold_d = rx_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      eidx_q <= '0;
      fmt_q  <= '0;
      tx_q   <= '0;
      rxs_q  <= '0;
      hold_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      eidx_q <= eidx_d;
      fmt_q  <= fmt_d;
      tx_q   <= tx_d;
      rxs_q  <= rxs_d;
      hold_q <= hold_d;
      rdy_q  <= rdy_d;
    end
  end

  assign busy     = busy_q;
  assign sclk     = busy_q ? (fmt_q.cpol ^ eidx_q[0]) : fmt_in.cpol;
  assign mosi     = busy_q && tx_q[WORD_W-1];
  assign rx_data  = hold_q;
  assign rx_ready = rdy_q;
endmodule

// File: rtl/spim_master.sv
module spim_master
  import spim_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_wide,
  input  logic              cfg_lsb_first,
  input  logic              cfg_cpha,
  input  logic              cfg_cpol,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              rx_read,
  output logic              idle,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  spim_fmt_t fmt_in;
  logic      start, busy, tick;

  assign fmt_in = '{wide: cfg_wide, lsb_first: cfg_lsb_first,
                    cpha: cfg_cpha, cpol: cfg_cpol};

  spim_baud #(.DIV_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start),
    .run    (busy),
    .div_in (cfg_div),
    .tick   (tick)
  );

  spim_engine #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt_in   (fmt_in),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .rx_read  (rx_read),
    .tick     (tick),
    .miso     (miso),
    .start    (start),
    .busy     (busy),
    .sclk     (sclk),
    .mosi     (mosi),
    .rx_data  (rx_data),
    .rx_ready (rx_ready)
  );

  assign idle     = !busy;
  assign tx_ready = !busy;
endmodule

// File: rtl/spim_master_chk.sv
module spim_master_chk (
  input logic clk,
  input logic rst_n,
  input logic idle,
  input logic tx_valid,
  input logic tx_ready,
  input logic sclk,
  input logic mosi,
  input logic cfg_cpol,
  input logic rx_ready,
  input logic rx_read
);
  assert_idle_clk_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (sclk == cfg_cpol));

  assert_idle_mosi_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mosi);

  assert_accept_leaves_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !idle);

  assert_no_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> !tx_ready);

  assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !rx_read) |=> rx_ready);

  assert_ready_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_read && idle) |=> !rx_ready);

  assert_half_period_min_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && $past(!idle) && !$stable(sclk)) |=> ($stable(sclk) || idle));
endmodule

bind spim_master spim_master_chk u_chk (.*);

// File: tb/spim_master_tb.sv
`timescale 1ns/1ps
module spim_master_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_div;
  logic        cfg_wide, cfg_lsb_first, cfg_cpha, cfg_cpol;
  logic [15:0] tx_data;
  logic        tx_valid, rx_read, miso;
  logic        tx_ready, rx_ready, idle, sclk, mosi;
  logic [15:0] rx_data;

  always #2.5 clk = ~clk;

  spim_master u_dut (.*);

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;
  logic [15:0] slave;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  bit          m_busy, m_rdy, m_lsb, m_cpha, m_cpol;
  int          m_cnt, m_d, m_edge, m_n;
  logic [15:0] m_tx, m_acc, m_rx;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_rdy = 0; m_rx = '0; m_edge = 0; m_cnt = 0;
      m_d = 1; m_n = 8; m_lsb = 0; m_cpha = 0; m_cpol = 0; m_tx = '0; m_acc = '0;
    end else begin
      bit set_rdy;
      set_rdy = 0;
      if (m_busy) begin
        if (m_cnt == m_d) begin
          bit lead, samp;
          m_cnt = 0;
          lead = (m_edge % 2 == 0);
          samp = m_cpha ? !lead : lead;
          if (samp) begin
            int k;
            k = m_edge / 2;
            if (m_lsb) m_acc[k] = miso; else m_acc[m_n-1-k] = miso;
            if (k == m_n - 1) set_rdy = 1;
          end
          if (m_edge == 2 * m_n - 1) m_busy = 0;
          m_edge++;
        end else begin
          m_cnt++;
        end
      end else if (tx_valid) begin
        m_busy = 1; m_cnt = 0; m_edge = 0; m_acc = '0;
        m_d = (cfg_div == 0) ? 1 : int'(cfg_div);
        m_n = cfg_wide ? 16 : 8;
        m_lsb = cfg_lsb_first; m_cpha = cfg_cpha; m_cpol = cfg_cpol;
        m_tx = tx_data;
      end
      if (rx_read) m_rdy = 0;
      if (set_rdy) begin m_rdy = 1; m_rx = m_acc; end
    end
  end

  // Compare on the falling edge, then drive the slave's next bit.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int k, nk;
      logic exp_sclk, exp_mosi;
      exp_sclk = m_busy ? (m_cpol ^ m_edge[0]) : cfg_cpol;
      k = m_cpha ? ((m_edge == 0) ? 0 : (m_edge - 1) / 2) : m_edge / 2;
      exp_mosi = m_busy ? (m_lsb ? m_tx[k] : m_tx[m_n-1-k]) : 1'b0;
      chk("R1", "sclk", 32'(sclk), 32'(exp_sclk));
      chk("R3", "mosi", 32'(mosi), 32'(exp_mosi));
      chk("R5", "idle", 32'(idle), 32'(!m_busy));
      chk("R6", "tx_ready", 32'(tx_ready), 32'(!m_busy));
      chk("R8", "rx_ready", 32'(rx_ready), 32'(m_rdy));
      chk("R7", "rx_data", 32'(rx_data), 32'(m_rx));
      nk = m_cpha ? m_edge / 2 : (m_edge + 1) / 2;
      if (m_busy && nk < m_n) miso = m_lsb ? slave[nk] : slave[m_n-1-nk];
      else miso = 1'b0;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  // One character; optional busy write, mid-transfer config change, held read.
  task automatic xfer(input logic [15:0] w, input logic [15:0] s,
                      input logic wide, input logic lsb, input logic cpha,
                      input logic cpol, input logic [7:0] div, input string tag,
                      input bit poke, input bit mess, input bit hold_rd);
    int dur, n, d;
    logic [15:0] mask;
    n = wide ? 16 : 8;
    d = (div == 0) ? 1 : int'(div);
    mask = wide ? 16'hFFFF : 16'h00FF;
    @(negedge clk);
    cfg_wide = wide; cfg_lsb_first = lsb; cfg_cpha = cpha; cfg_cpol = cpol;
    cfg_div = div; tx_data = w; tx_valid = 1'b1; slave = s;
    if (hold_rd) rx_read = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    dur = 0;
    while (!idle) begin
      dur++;
      if (poke && dur == 3) begin tx_valid = 1'b1; tx_data = ~w; end
      else tx_valid = 1'b0;
      if (mess && dur == 2) begin
        cfg_wide = !wide; cfg_lsb_first = !lsb; cfg_cpha = !cpha;
        cfg_cpol = !cpol; cfg_div = 8'd0;
      end
      @(negedge clk);
    end
    tx_valid = 1'b0;
    rx_read = 1'b0;
    chk({tag, " R1"}, "busy cycles", 32'(dur), 32'(2 * n * (d + 1)));
    chk({tag, " R7"}, "received", 32'(rx_data), 32'(s & mask));
    chk({tag, " R8"}, "ready after transfer", 32'(rx_ready), 32'd1);
    cfg_cpol = cpol;
    @(negedge clk);
    rx_read = 1'b1;
    @(negedge clk);
    rx_read = 1'b0;
    chk({tag, " R8"}, "ready after read", 32'(rx_ready), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_div = 8'd1; cfg_wide = 0; cfg_lsb_first = 0; cfg_cpha = 0; cfg_cpol = 0;
    tx_data = '0; tx_valid = 0; rx_read = 0; miso = 0; slave = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10", "idle", 32'(idle), 32'd1);
    chk("R10", "tx_ready", 32'(tx_ready), 32'd1);
    chk("R10", "rx_ready", 32'(rx_ready), 32'd0);
    chk("R10", "rx_data", 32'(rx_data), 32'd0);
    chk("R10", "mosi", 32'(mosi), 32'd0);
    // R5: rest level follows polarity while idle
    cfg_cpol = 1'b1;
    #1 chk("R5", "sclk rest high", 32'(sclk), 32'd1);
    cfg_cpol = 1'b0;
    #1 chk("R5", "sclk rest low", 32'(sclk), 32'd0);

    xfer(16'h00A5, 16'h003C, 0, 0, 0, 0, 8'd1, "R2 R4 mode0 msb8", 0, 0, 0);
    xfer(16'hBEEF, 16'h1357, 1, 0, 1, 0, 8'd2, "R2 R4 mode1 msb16", 0, 0, 0);
    xfer(16'h0081, 16'h00C6, 0, 1, 0, 1, 8'd1, "R3 R4 mode2 lsb8", 0, 0, 0);
    xfer(16'h8C31, 16'hF00D, 1, 1, 1, 1, 8'd3, "R3 R4 mode3 lsb16", 0, 0, 0);
    xfer(16'h005A, 16'h0096, 0, 0, 0, 0, 8'd0, "R1 div0", 0, 0, 0);
    xfer(16'h00C3, 16'h0071, 0, 1, 1, 0, 8'd255, "R1 div255", 0, 0, 0);
    xfer(16'h1234, 16'hABCD, 0, 0, 1, 1, 8'd2, "R7 narrow", 0, 0, 0);
    xfer(16'h6A0F, 16'h9E21, 1, 0, 0, 0, 8'd1, "R6 busy write", 1, 0, 0);
    xfer(16'h00E7, 16'h0018, 0, 0, 1, 0, 8'd2, "R9 cfg change", 0, 1, 0);
    xfer(16'h4DB2, 16'h2B6C, 1, 1, 1, 0, 8'd1, "R8 set wins", 0, 0, 1);

    repeat (4) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule